// File: doc/BRIEF.md
# Backup-Powered Scratch RAM with Manual Wipe

This block holds 114 bytes of general-purpose storage that a host reads and writes through a simple synchronous port. The host sees a 128-byte map. The low 14 addresses (0 to 13) belong to the clock register file. For those addresses this block only raises a select strobe and does not serve the access. The upper 114 addresses (14 to 127) are stored here.

An active-low wipe input fills every stored byte with 0xFF. The wipe works only while the block runs from the backup supply. The input is synchronised and must be seen low on two consecutive samples before a wipe begins. The wipe then writes one byte per clock and always runs over all 114 bytes. Host access is shut off while the power-fail input is high. The reset input clears only the control state; stored bytes are kept.

Top module: `backup_ram`

## Requirements
- R1: A host write (hostEn=1, hostWe=1) to an address 14..127 stores hostWdata. A later host read (hostEn=1, hostWe=0) of that address returns it on hostRdata, with rdValid=1 in the cycle after the read request.
- R2: For a host access to an address 0..13, rtcSel is 1 in that same cycle, rdValid stays 0 and no stored byte changes. For addresses 14..127, rtcSel is 0.
- R3: While powerFail=1, host requests are ignored: rtcSel=0, rdValid=0 and no stored byte changes.
- R4: When wipeN is sampled low on two consecutive synchronised samples while onBattery=1, every stored byte (addresses 14..127) becomes 0xFF.
- R5: While onBattery=0, holding wipeN low changes no stored byte.
- R6: A low pulse on wipeN lasting one clock cycle changes no stored byte.
- R7: Once a wipe has started, it covers all 114 bytes even if wipeN returns high part way through.
- R8: While a wipe is running, the wipe owns the write path. Host writes are dropped, and host reads are still served with rdValid=1.
- R9: Asserting rstN leaves stored bytes unchanged. After reset, rdValid=0 and hostRdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low async reset of control state |
| powerFail | input | 1 | 1 = supply below threshold, host blocked |
| onBattery | input | 1 | 1 = main supply absent, wipe permitted |
| wipeN | input | 1 | Active-low asynchronous wipe request |
| hostEn | input | 1 | Host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 7 | Host byte address in the 128-byte map |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data, registered |
| rdValid | output | 1 | hostRdata valid for the previous read |
| rtcSel | output | 1 | Access falls in the clock register range 0..13 |

## Verification
A wipe sweep and a host write can land in the same cycle. This happens when onBattery=1 while powerFail=0. The bench starts a wipe and releases wipeN after a few cycles. It then writes 0x55 to address 14, which the sweep has already passed, and issues a read while the sweep is still running. The result is judged in two ways: the read must return rdValid=1, and after the sweep address 14 must still hold 0xFF, like every other byte.

// File: rtl/backup_ram_pkg.sv
package backup_ram_pkg;
  localparam int NUM_BYTES = 114;
  localparam int MAP_SIZE  = 128;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = $clog2(MAP_SIZE);
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int BASE      = MAP_SIZE - NUM_BYTES;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
    logic              rdEn;
    logic [IDX_W-1:0]  rdIdx;
  } memStrobe_t;
endpackage

// File: rtl/backup_ram_ctrl.sv
module backup_ram_ctrl
  import backup_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              onBattery,
  input  logic              wipeN,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output memStrobe_t        strobe,
  output logic              rtcSel
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic [1:0]       wipeSync;
  logic             wipePrev;
  logic             sweeping;
  logic [IDX_W-1:0] sweepIdx;
  logic             startWipe;
  logic             accessOk;
  logic             inRange;
  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0] hostIdx;

  // two-stage synchroniser plus one history bit for the glitch filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipeSync <= 2'b11;
      wipePrev <= 1'b1;
    end else begin
      wipeSync <= {wipeSync[0], wipeN};
      wipePrev <= wipeSync[1];
    end
  end

  assign startWipe = !wipeSync[1] && !wipePrev && onBattery && !sweeping;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweeping <= 1'b0;
      sweepIdx <= '0;
    end else if (startWipe) begin
      sweeping <= 1'b1;
      sweepIdx <= '0;
    end else if (sweeping) begin
      if (sweepIdx == LAST_IDX) sweeping <= 1'b0;
      else                      sweepIdx <= sweepIdx + 1'b1;
    end
  end

  assign accessOk = hostEn && !powerFail;
  assign inRange  = hostAddr >= ADDR_W'(BASE);
  assign offset   = hostAddr - ADDR_W'(BASE);
  assign hostIdx  = IDX_W'(offset);
  assign rtcSel   = accessOk && !inRange;

  always_comb begin
    strobe.wrEn   = sweeping || (accessOk && inRange && hostWe);
    strobe.wrIdx  = sweeping ? sweepIdx : hostIdx;
    strobe.wrData = sweeping ? '1 : hostWdata;
    strobe.rdEn   = accessOk && inRange && !hostWe;
    strobe.rdIdx  = hostIdx;
  end

  // R7: a started sweep keeps running until the last byte
  a_r7_sweep_runs_on: assert property (@(posedge clk) disable iff (!rstN)
    (sweeping && sweepIdx != LAST_IDX) |=> sweeping);

  // R4: the sweep visits consecutive bytes
  a_r4_sweep_steps: assert property (@(posedge clk) disable iff (!rstN)
    (sweeping && sweepIdx != LAST_IDX) |=> (sweepIdx == $past(sweepIdx) + 1'b1));

  // R6: a sweep begins only after two low samples on battery
  a_r6_two_low_samples: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sweeping) |-> $past(!wipeSync[1] && !wipePrev && onBattery));

  // R8: during a sweep only 0xFF reaches the array
  a_r8_sweep_owns_write: assert property (@(posedge clk) disable iff (!rstN)
    (sweeping && hostEn && hostWe) |-> (strobe.wrData == '1 && strobe.wrIdx == sweepIdx));

  // R3: no host-driven strobe while power fails
  a_r3_host_blocked: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> (!strobe.rdEn && !rtcSel && (!strobe.wrEn || sweeping)));
endmodule

// File: rtl/backup_ram_dp.sv
module backup_ram_dp
  import backup_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] mem [NUM_BYTES];

  // storage has no reset: contents survive rstN
  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[strobe.wrIdx] <= strobe.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= mem[strobe.rdIdx];
    end
  end

  // R1: every read request yields valid data one cycle later
  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rdValid);

  // R1: no valid flag without a request
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> !rdValid);
endmodule

// File: rtl/backup_ram.sv
module backup_ram
  import backup_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              onBattery,
  input  logic              wipeN,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              rdValid,
  output logic              rtcSel
);
  memStrobe_t strobe;

  backup_ram_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .onBattery(onBattery),
    .wipeN(wipeN), .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .strobe(strobe), .rtcSel(rtcSel)
  );

  backup_ram_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdData(hostRdata), .rdValid(rdValid)
  );

  // R2: clock-register accesses never reach the array read path
  a_r2_rtc_excluded: assert property (@(posedge clk) disable iff (!rstN)
    rtcSel |=> !rdValid);
endmodule

// File: tb/test_backup_ram.sv
module test_backup_ram;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerFail = 1'b0, onBattery = 1'b0, wipeN = 1'b1;
  logic hostEn = 1'b0, hostWe = 1'b0;
  logic [6:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic rdValid, rtcSel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic gotSel, gotValid;
  logic [7:0] gotData;

  always #2 clk = ~clk;

  backup_ram i_backup_ram (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .onBattery(onBattery),
    .wipeN(wipeN), .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .rdValid(rdValid), .rtcSel(rtcSel)
  );

  // {we, addr, wdata, expected read}
  localparam logic [23:0] VEC [10] = '{
    {1'b1, 7'd14,  8'hA5, 8'h00},
    {1'b1, 7'd127, 8'h3C, 8'h00},
    {1'b1, 7'd60,  8'h0F, 8'h00},
    {1'b1, 7'd13,  8'h77, 8'h00},
    {1'b1, 7'd15,  8'h5A, 8'h00},
    {1'b0, 7'd14,  8'h00, 8'hA5},
    {1'b0, 7'd127, 8'h00, 8'h3C},
    {1'b0, 7'd60,  8'h00, 8'h0F},
    {1'b0, 7'd15,  8'h00, 8'h5A},
    {1'b0, 7'd0,   8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [6:0] addr, input logic [7:0] data);
    @(negedge clk);
    hostEn = 1'b1; hostWe = we; hostAddr = addr; hostWdata = data;
    #1 gotSel = rtcSel;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0;
    gotValid = rdValid;
    gotData = hostRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset rdValid", {7'd0, rdValid}, 8'd0);
    check("R9 reset rdata", hostRdata, 8'h00);

    // vector table
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][23], VEC[i][22:16], VEC[i][15:8]);
      if (VEC[i][22:16] < 7'd14) begin
        check("R2 rtcSel", {7'd0, gotSel}, 8'd1);
        check("R2 no rdValid", {7'd0, gotValid}, 8'd0);
      end else begin
        check("R2 rtcSel low", {7'd0, gotSel}, 8'd0);
        if (!VEC[i][23]) begin
          check("R1 rdValid", {7'd0, gotValid}, 8'd1);
          check("R1 data", gotData, VEC[i][7:0]);
        end
      end
    end

    // R3: blocked while power fails
    powerFail = 1'b1;
    access(1'b1, 7'd14, 8'hEE);
    check("R3 rtcSel off", {7'd0, gotSel}, 8'd0);
    access(1'b0, 7'd14, 8'h00);
    check("R3 no rdValid", {7'd0, gotValid}, 8'd0);
    access(1'b0, 7'd3, 8'h00);
    check("R3 rtc blocked", {7'd0, gotSel}, 8'd0);
    powerFail = 1'b0;
    access(1'b0, 7'd14, 8'h00);
    check("R3 data kept", gotData, 8'hA5);

    // R9: reset keeps contents
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(1'b0, 7'd127, 8'h00);
    check("R9 contents kept", gotData, 8'h3C);

    // R5: wipe ignored on main supply
    onBattery = 1'b0;
    @(negedge clk); wipeN = 1'b0;
    repeat (140) @(negedge clk);
    wipeN = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 7'd60, 8'h00);
    check("R5 no wipe on main", gotData, 8'h0F);

    // R6: single-cycle glitch ignored
    onBattery = 1'b1;
    @(negedge clk); wipeN = 1'b0;
    @(negedge clk); wipeN = 1'b1;
    repeat (140) @(negedge clk);
    access(1'b0, 7'd15, 8'h00);
    check("R6 glitch ignored", gotData, 8'h5A);

    // R7 + R8: short wipe request, host write and read collide with sweep
    @(negedge clk); wipeN = 1'b0;
    repeat (5) @(negedge clk);
    wipeN = 1'b1;
    repeat (5) @(negedge clk);
    access(1'b1, 7'd14, 8'h55);
    access(1'b0, 7'd100, 8'h00);
    check("R8 read during wipe", {7'd0, gotValid}, 8'd1);
    repeat (130) @(negedge clk);
    onBattery = 1'b0;
    access(1'b0, 7'd14, 8'h00);
    check("R8 host write dropped", gotData, 8'hFF);
    for (int a = 14; a < 128; a++) begin
      access(1'b0, 7'(a), 8'h00);
      check(a == 127 ? "R7 last byte wiped" : "R4 byte wiped", gotData, 8'hFF);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule